// File: doc/BRIEF.md
# SDR SDRAM Command Timing Controller

This block connects a host that issues one 16-bit word per request to a single-rank SDR SDRAM with four banks. Each accepted request is split into bank, row and column fields. The block then drives a closed-page command train on the memory pins: ACTIVATE, then READ or WRITE, then PRECHARGE. No row is left open between requests. Every gap between commands meets a fixed timing set for a 100 MHz memory clock with a CAS latency of 2. The write-recovery gap is raised to tRAS − tRCD when that value is larger than the device minimum.

A free-running interval counter raises a refresh request on a fixed period. That period is the per-row refresh interval less a safety margin of 20 clocks. A pending refresh beats any new host request. The AUTO REFRESH goes out only when all banks are closed and the row-cycle time has elapsed. A separate power-up sequencer reports completion on `init_done`. Until then the block issues only NOP and accepts nothing.

The request port uses valid/ready. The host keeps `req_valid` and its fields stable until a cycle in which `req_ready` is high; the transfer happens at the edge that ends that cycle. `req_ready` goes low from acceptance until the next ACTIVATE is legal, so the port takes at most one request per access. The read response is a one-cycle `rsp_valid` pulse with data and has no back-pressure: the host must always take it.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: A host address is split as bank = `req_addr[22:21]`, row = `req_addr[20:9]`, column = `req_addr[8:0]`. The row goes on `sd_a[11:0]` with ACTIVATE. The column goes on `sd_a[8:0]` with READ/WRITE. Both go out with the bank on `sd_ba`.
- R2: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP=0111, ACTIVATE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001. Each accepted request produces exactly one ACTIVATE, then one READ or WRITE to the same bank with `sd_a[10]`=0, then one PRECHARGE of that bank. No other ACTIVATE occurs while a bank is open.
- R3: A READ or WRITE comes at least 2 cycles after the ACTIVATE of its bank.
- R4: A PRECHARGE comes at least 5 cycles after the ACTIVATE and at least 3 cycles after a WRITE to that bank.
- R5: An ACTIVATE comes at least 2 cycles after the last PRECHARGE of its bank. Any ACTIVATE or AUTO REFRESH comes at least 6 cycles after the previous ACTIVATE or AUTO REFRESH.
- R6: When READ is on the pins in cycle c, `rsp_valid` is high for exactly cycle c+5. `rsp_data` carries the `sd_dq_in` value sampled at the edge ending cycle c+2, which is CAS latency 2 plus a 2-stage return pipe.
- R7: `sd_dq_oe` is high exactly in the cycles that carry WRITE. In those cycles `sd_dq_out` holds the write data of that request.
- R8: With no host traffic, consecutive AUTO REFRESH commands are exactly 1543 cycles apart (a reload value of 1542). With traffic they stay within 7 cycles of that.
- R9: An AUTO REFRESH is issued only with all banks closed. A pending refresh holds `req_ready` low and goes out ahead of any waiting request.
- R10: While `init_done` is low the pins carry only NOP and `req_ready` stays low, even with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Power-up sequence finished |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address pins |
| sd_dq_out | output | 16 | Data to the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
Directed accesses hit the address extremes (all zeros, all ones, every bank, the last column). These show whether the bank, row and column fields are sliced at the right bit positions. An overwrite followed by a read-back, and a write immediately followed by a read, show whether read data is captured in the correct cycle rather than one early or late. A long run of mixed reads and writes over a pool of addresses makes refresh expiries fall at every point of an access, which exposes refresh priority and row-cycle errors. A quiet stretch at the end measures the exact refresh period, free of traffic-induced delay.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RW,
    ST_PRE
  } sdr_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Down counter that reports when a minimum command gap has elapsed.
// Loading N at the edge that issues a command makes done high in the
// cycle N-1 later, so the next command lands N cycles after the first.
module sdr_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val - W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
// Free-running refresh interval counter with a sticky request flag.
module sdr_refresh_timer #(
  parameter int RELOAD = 1542
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);

  localparam int CW = $clog2(RELOAD + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= CW'(RELOAD);
      pend_q <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= CW'(RELOAD);
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
        if (ack) pend_q <= 1'b0;
      end
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/sdr_read_pipe.sv
// Tracks issued reads, samples the data bus after the CAS latency and
// delays the word through a fixed return pipe.
module sdr_read_pipe #(
  parameter int CL   = 2,
  parameter int PIPE = 2,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_on_bus,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  localparam int DEPTH = CL + PIPE + 1;

  logic [DEPTH-1:0]        vld_sr;
  logic [PIPE:0][DW-1:0]   dat_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
      dat_sr <= '0;
    end else begin
      vld_sr <= {vld_sr[DEPTH-2:0], rd_on_bus};
      if (vld_sr[CL-1]) dat_sr[0] <= dq_in;
      for (int k = 1; k <= PIPE; k++) begin
        dat_sr[k] <= dat_sr[k-1];
      end
    end
  end

  assign rsp_valid = vld_sr[DEPTH-1];
  assign rsp_data  = dat_sr[PIPE];

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdr_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DQ_W       = 16,
  parameter int APIN_W     = 12,
  parameter int T_RCD      = 2,
  parameter int T_RP       = 2,
  parameter int T_RAS      = 5,
  parameter int T_RC       = 6,
  parameter int T_WR_DEV   = 2,
  parameter int CAS_LAT    = 2,
  parameter int RD_PIPE    = 2,
  parameter int REF_RELOAD = 1542
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            init_done,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_we,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]                 req_wdata,
  output logic                            rsp_valid,
  output logic [DQ_W-1:0]                 rsp_data,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [APIN_W-1:0]               sd_a,
  output logic [DQ_W-1:0]                 sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DQ_W-1:0]                 sd_dq_in
);

  localparam int HA_W  = BANK_W + ROW_W + COL_W;
  localparam int T_WR  = imax(T_WR_DEV, T_RAS - T_RCD);
  localparam int GAP_W = $clog2(imax(imax(T_RC, T_RAS), imax(T_WR, T_RP)) + 1);

  // address field split
  logic [BANK_W-1:0] bank_in;
  logic [ROW_W-1:0]  row_in;
  logic [COL_W-1:0]  col_in;
  assign bank_in = req_addr[HA_W-1 -: BANK_W];
  assign row_in  = req_addr[COL_W +: ROW_W];
  assign col_in  = req_addr[COL_W-1:0];

  // state and registered pins
  sdr_state_e        state_q, state_n;
  sdr_cmd_e          cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_q, ba_n;
  logic [APIN_W-1:0] a_q, a_n;
  logic [DQ_W-1:0]   dq_out_q;
  logic              oe_q;

  // latched request
  logic              lat_we;
  logic [BANK_W-1:0] lat_ba;
  logic [COL_W-1:0]  lat_col;
  logic [DQ_W-1:0]   lat_wd;

  // timer controls
  logic             gap_ld, ras_ld, rc_ld;
  logic [GAP_W-1:0] gap_val;
  logic             gap_done, ras_done, rc_done;
  logic             ref_pend, ref_ack;
  logic             accept;

  sdr_gap_timer #(.W(GAP_W)) u_cmd_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_ld), .load_val(gap_val), .done(gap_done)
  );

  sdr_gap_timer #(.W(GAP_W)) u_ras_gap (
    .clk(clk), .rst_n(rst_n), .load(ras_ld), .load_val(GAP_W'(T_RAS)), .done(ras_done)
  );

  sdr_gap_timer #(.W(GAP_W)) u_rc_gap (
    .clk(clk), .rst_n(rst_n), .load(rc_ld), .load_val(GAP_W'(T_RC)), .done(rc_done)
  );

  sdr_refresh_timer #(.RELOAD(REF_RELOAD)) u_ref_tmr (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
  );

  sdr_read_pipe #(.CL(CAS_LAT), .PIPE(RD_PIPE), .DW(DQ_W)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .rd_on_bus(cmd_q == CMD_RD),
    .dq_in(sd_dq_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  logic slot_free;
  assign slot_free = (state_q == ST_IDLE) && init_done && gap_done && rc_done;
  assign req_ready = slot_free && !ref_pend;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_n = state_q;
    cmd_n   = CMD_NOP;
    ba_n    = ba_q;
    a_n     = '0;
    gap_ld  = 1'b0;
    gap_val = GAP_W'(1);
    ras_ld  = 1'b0;
    rc_ld   = 1'b0;
    ref_ack = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (slot_free && ref_pend) begin
          cmd_n   = CMD_REF;
          gap_ld  = 1'b1;
          gap_val = GAP_W'(T_RC);
          rc_ld   = 1'b1;
          ref_ack = 1'b1;
        end else if (accept) begin
          cmd_n   = CMD_ACT;
          ba_n    = bank_in;
          a_n     = APIN_W'(row_in);
          gap_ld  = 1'b1;
          gap_val = GAP_W'(T_RCD);
          ras_ld  = 1'b1;
          rc_ld   = 1'b1;
          state_n = ST_RW;
        end
      end
      ST_RW: begin
        if (gap_done) begin
          cmd_n   = lat_we ? CMD_WR : CMD_RD;
          ba_n    = lat_ba;
          a_n     = APIN_W'(lat_col);
          gap_ld  = 1'b1;
          gap_val = lat_we ? GAP_W'(T_WR) : GAP_W'(1);
          state_n = ST_PRE;
        end
      end
      ST_PRE: begin
        if (gap_done && ras_done) begin
          cmd_n   = CMD_PRE;
          ba_n    = lat_ba;
          gap_ld  = 1'b1;
          gap_val = GAP_W'(T_RP);
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      ba_q     <= '0;
      a_q      <= '0;
      dq_out_q <= '0;
      oe_q     <= 1'b0;
      lat_we   <= 1'b0;
      lat_ba   <= '0;
      lat_col  <= '0;
      lat_wd   <= '0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd_n;
      ba_q    <= ba_n;
      a_q     <= a_n;
      oe_q    <= (cmd_n == CMD_WR);
      if (cmd_n == CMD_WR) dq_out_q <= lat_wd;
      if (accept) begin
        lat_we  <= req_we;
        lat_ba  <= bank_in;
        lat_col <= col_in;
        lat_wd  <= req_wdata;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dq_out = dq_out_q;
  assign sd_dq_oe  = oe_q;

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk
  import sdr_pkg::*;
#(
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 5,
  parameter int T_RC     = 6,
  parameter int T_WR_DEV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic init_done,
  input logic req_ready,
  input logic rsp_valid,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_dq_oe
);

  localparam int T_WR = imax(T_WR_DEV, T_RAS - T_RCD);

  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  logic [3:0] since_act, since_wr, since_pre, since_row;

  function automatic logic [3:0] bump(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 4'hF;
      since_wr  <= 4'hF;
      since_pre <= 4'hF;
      since_row <= 4'hF;
    end else begin
      since_act <= (cmd == CMD_ACT) ? 4'd1 : bump(since_act);
      since_wr  <= (cmd == CMD_WR)  ? 4'd1 : bump(since_wr);
      since_pre <= (cmd == CMD_PRE) ? 4'd1 : bump(since_pre);
      since_row <= (cmd == CMD_ACT || cmd == CMD_REF) ? 4'd1 : bump(since_row);
    end
  end

  AST_QUIET_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (cmd == CMD_NOP) && !req_ready); // R10

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= 4'(T_RCD)); // R3

  AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> since_act >= 4'(T_RAS)); // R4

  AST_WRITE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> since_wr >= 4'(T_WR)); // R4

  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> since_pre >= 4'(T_RP)); // R5

  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> since_row >= 4'(T_RC)); // R5

  AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> since_pre <= since_act); // R9

  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe == (cmd == CMD_WR)); // R7

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_WR_DEV(T_WR_DEV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_cmd_ctrl_tb_top.sv
module sdram_cmd_ctrl_tb_top;
  import sdr_pkg::*;

  localparam int REF_PERIOD = 1543;
  localparam int RD_LAT     = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out;
  logic        sd_dq_oe;
  logic [15:0] sd_dq_in;

  sdram_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  typedef struct {
    bit          we;
    logic [1:0]  ba;
    logic [11:0] row;
    logic [8:0]  col;
    logic [15:0] data;
  } acc_t;

  acc_t        acc_q[$];
  logic [15:0] exp_q[$];
  int          due_q[$];
  logic [15:0] ref_mem[int];
  logic [15:0] model_mem[int];

  // ---------------- SDRAM behavioural model with timing checks ----------
  int          t_act[4];
  int          t_pre[4];
  int          t_wr[4];
  int          t_row = -100;
  int          t_ref = -1;
  int          quiet_from = 32'h7fffffff;
  int          n_ref = 0;
  int          n_quiet_exact = 0;
  bit          open_b[4];
  logic [11:0] open_row[4];
  logic [15:0] rd_m1 = '0, rd_m2 = '0;

  assign sd_dq_in = rd_m2;

  initial begin
    for (int i = 0; i < 4; i++) begin
      t_act[i] = -100; t_pre[i] = -100; t_wr[i] = -100; open_b[i] = 0; open_row[i] = '0;
    end
  end

  always @(posedge clk) begin : model
    logic [3:0] cmd;
    int c;
    int b;
    int key;
    acc_t a;
    logic [15:0] rd_val;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    c = cyc;
    b = int'(sd_ba);
    rd_val = 16'hB000 ^ c[15:0];
    if (rst_n) begin
      if (sd_dq_oe && cmd != CMD_WR) check(0, "R7", "oe outside WRITE", 1, 0);
      case (cmd)
        CMD_NOP: ;
        CMD_ACT: begin
          check(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R2", "ACT with open bank", 1, 0);
          check(c - t_row >= 6, "R5", "tRC before ACT", c - t_row, 6);
          check(c - t_pre[b] >= 2, "R5", "tRP before ACT", c - t_pre[b], 2);
          open_b[b] = 1; open_row[b] = sd_a; t_act[b] = c; t_row = c;
        end
        CMD_RD, CMD_WR: begin
          check(open_b[b], "R2", "column cmd on closed bank", 0, 1);
          check(c - t_act[b] >= 2, "R3", "tRCD", c - t_act[b], 2);
          check(sd_a[10] == 1'b0, "R2", "auto-precharge bit", sd_a[10], 0);
          if (acc_q.size() == 0) begin
            check(0, "R2", "column cmd without request", 1, 0);
          end else begin
            a = acc_q.pop_front();
            check(a.we == (cmd == CMD_WR), "R2", "read/write kind", cmd == CMD_WR, a.we);
            check(sd_ba == a.ba, "R1", "bank field", sd_ba, a.ba);
            check(open_row[b] == a.row, "R1", "row field", open_row[b], a.row);
            check(sd_a[8:0] == a.col, "R1", "column field", sd_a[8:0], a.col);
            key = int'({sd_ba, open_row[b], sd_a[8:0]});
            if (cmd == CMD_WR) begin
              check(sd_dq_oe, "R7", "oe on WRITE", sd_dq_oe, 1);
              check(sd_dq_out == a.data, "R7", "write data", sd_dq_out, a.data);
              model_mem[key] = sd_dq_out;
              t_wr[b] = c;
            end else begin
              rd_val = model_mem.exists(key) ? model_mem[key] : 16'h0000;
              due_q.push_back(c + RD_LAT);
            end
          end
        end
        CMD_PRE: begin
          check(open_b[b], "R2", "PRE of closed bank", 0, 1);
          check(c - t_act[b] >= 5, "R4", "tRAS", c - t_act[b], 5);
          check(c - t_wr[b] >= 3, "R4", "write recovery", c - t_wr[b], 3);
          open_b[b] = 0; t_pre[b] = c;
        end
        CMD_REF: begin
          check(!(open_b[0] | open_b[1] | open_b[2] | open_b[3]), "R9", "REF with open bank", 1, 0);
          check(c - t_row >= 6, "R5", "tRC before REF", c - t_row, 6);
          check(init_done, "R10", "REF before init", init_done, 1);
          if (t_ref >= 0) begin
            check((c - t_ref >= REF_PERIOD - 7) && (c - t_ref <= REF_PERIOD + 7),
                  "R8", "refresh spacing bound", c - t_ref, REF_PERIOD);
            if (t_ref >= quiet_from) begin
              check(c - t_ref == REF_PERIOD, "R8", "quiet refresh period", c - t_ref, REF_PERIOD);
              n_quiet_exact++;
            end
          end
          t_ref = c; t_row = c; n_ref++;
        end
        default: check(0, "R2", "illegal command code", cmd, CMD_NOP);
      endcase
    end
    rd_m1 <= (cmd == CMD_RD) ? rd_val : 16'hB000 ^ c[15:0];
    rd_m2 <= rd_m1;
  end

  // ---------------- response monitor / scoreboard -----------------------
  always @(negedge clk) begin : monitor
    int due;
    logic [15:0] e;
    if (rst_n && rsp_valid) begin
      if (due_q.size() == 0 || exp_q.size() == 0) begin
        check(0, "R6", "unexpected rsp_valid", 1, 0);
      end else begin
        due = due_q.pop_front();
        e = exp_q.pop_front();
        check(cyc == due, "R6", "read latency", cyc, due);
        check(rsp_data == e, "R6", "read data", rsp_data, e);
      end
    end
  end

  // ---------------- driver ---------------------------------------------
  task automatic access(input bit we, input logic [22:0] addr, input logic [15:0] d);
    acc_t a;
    a.we = we; a.ba = addr[22:21]; a.row = addr[20:9]; a.col = addr[8:0]; a.data = d;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc_q.push_back(a);
    if (we) ref_mem[int'(addr)] = d;
    else exp_q.push_back(ref_mem.exists(int'(addr)) ? ref_mem[int'(addr)] : 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [22:0] pool_addr(input int i);
    return {i[1:0], 12'((i * 257) % 4096), 9'((i * 37) % 512)};
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "R2", "watchdog expired", 1, 0);
    report();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check(!rsp_valid && !sd_dq_oe && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP,
          "R10", "reset state", {rsp_valid, sd_dq_oe}, 0);
    rst_n = 1'b1;
    // R10: request held while init not done
    req_valid = 1'b1; req_we = 1'b1; req_addr = 23'h123; req_wdata = 16'h5555;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(!req_ready, "R10", "ready before init", req_ready, 0);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R10", "NOP before init",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, CMD_NOP);
    end
    req_valid = 1'b0;
    init_done = 1'b1;

    // directed: R1 field extremes, R6/R7 data paths
    access(1, 23'h000000, 16'h1111);
    access(1, 23'h7FFFFF, 16'hFFFE);
    access(1, {2'd1, 12'hABC, 9'h155}, 16'hA5A5);
    access(1, {2'd2, 12'h001, 9'h1FF}, 16'h5A5A);
    access(0, {2'd2, 12'h001, 9'h1FF}, 16'h0);
    access(0, {2'd1, 12'hABC, 9'h155}, 16'h0);
    access(0, 23'h7FFFFF, 16'h0);
    access(0, 23'h000000, 16'h0);
    access(1, 23'h000000, 16'h2222);       // overwrite
    access(0, 23'h000000, 16'h0);
    access(1, {2'd3, 12'h800, 9'h000}, 16'hC0DE);
    access(1, {2'd3, 12'h800, 9'h001}, 16'hBEEF);
    access(0, {2'd3, 12'h800, 9'h001}, 16'h0);
    access(0, {2'd3, 12'h800, 9'h000}, 16'h0);
    access(0, {2'd0, 12'h555, 9'h0AA}, 16'h0); // never written

    // mixed traffic across refresh expiries (R8, R9)
    for (int i = 0; i < 600; i++) begin
      access(1'($urandom_range(0, 1)), pool_addr(int'($urandom_range(0, 15))),
             16'($urandom));
    end

    // quiet window: exact refresh period (R8)
    repeat (20) @(negedge clk);
    quiet_from = cyc + 10;
    repeat (3300) @(negedge clk);

    check(n_quiet_exact > 0, "R8", "quiet refresh pairs seen", n_quiet_exact, 1);
    check(n_ref >= 4, "R9", "refreshes during run", n_ref, 4);
    check(acc_q.size() == 0, "R2", "requests without column cmd", acc_q.size(), 0);
    check(due_q.size() == 0 && exp_q.size() == 0, "R6", "reads without response",
          due_q.size() + exp_q.size(), 0);
    report();
  end

endmodule